// File: doc/BRIEF.md
# Programmable Rate Divider with Heartbeat Strobe

This block takes a fast system clock and derives three slower periodic signals from it, with no clock buffers or PLLs. The first is a power-of-two square wave, read as the top bit of a free-running binary counter. The second is a square wave whose half-period is a programmable number of input cycles, made by a counter that restarts at a threshold rather than at natural overflow. The third is a heartbeat strobe that rises once per full period of that square wave and stays high for a configurable number of input cycles.

All three outputs are registered signals in the input clock domain. They are meant as clock enables or as signals to observe, never as clocks for other flip-flops. A synchronous reset clears the block, and an enable input lets the surrounding logic freeze every counter in place. With a 100 MHz input, a 27-bit power-of-two counter gives about 0.745 Hz on its top bit, and a threshold of 50,000,000 gives a 1 Hz heartbeat.

Top module: `rate_divider`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high at a clock edge, every counter clears and `powClk`, `divClk` and `heartbeat` are low after that edge.
- R2: `powClk` is bit POW_WIDTH-1 of a counter that increments on each enabled edge, so after n enabled edges since reset it equals bit POW_WIDTH-1 of n (period 2^POW_WIDTH enabled cycles).
- R3: A threshold counter runs from 0 to THRESHOLD-1 and wraps. `divClk` toggles at each wrap, so after n enabled edges since reset it equals floor(n / THRESHOLD) mod 2.
- R4: `heartbeat` goes high on the same edge at which `divClk` goes from low to high, so it starts once every 2*THRESHOLD enabled cycles, first after THRESHOLD enabled edges.
- R5: Once high, `heartbeat` stays high for exactly ON_TIME enabled cycles. After n enabled edges it is high when (n mod 2*THRESHOLD) lies in [THRESHOLD, THRESHOLD+ON_TIME-1].
- R6: At an edge where `en` is low, every counter and every output holds its value.
- R7: At the boundary THRESHOLD = 1 with ON_TIME = 1, `divClk` toggles on every enabled edge and `heartbeat` is a single-cycle pulse on every second enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable; low freezes all state |
| powClk | output | 1 | Power-of-two divided square wave |
| divClk | output | 1 | Threshold-divided square wave |
| heartbeat | output | 1 | Periodic strobe of ON_TIME cycles |

## Verification
The bound checker checks on every cycle that a rising heartbeat coincides with a rising `divClk` and the other way round, that a heartbeat never outlives ON_TIME enabled cycles, that a disabled edge changes no output, and that reset leaves every output low. Only the bench's scenarios can show the absolute periods and phases: that `powClk` follows the top bit of the enabled-edge count, that `divClk` flips after exactly THRESHOLD enabled edges, and that the first heartbeat lands after THRESHOLD edges. The bench compares these against a count of enabled edges. It uses two configurations, one of them at the THRESHOLD = 1 boundary.

// File: rtl/rate_div_pkg.sv
package rate_div_pkg;

  // Bits needed to hold values 0 .. n-1, never less than one.
  function automatic int cntWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Strobes from the control side to the datapath, valid for one edge.
  typedef struct packed {
    logic tick;       // enabled edge: free-running counter advances
    logic wrap;       // threshold counter wraps on this edge
    logic beatStart;  // divided clock rises on this edge
  } divStrobe_t;

endpackage

// File: rtl/rate_div_ctrl.sv
module rate_div_ctrl
  import rate_div_pkg::*;
#(
  parameter int THRESHOLD = 50_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       divClk,
  output divStrobe_t strobes
);

  localparam int THR_W = cntWidth(THRESHOLD);
  localparam logic [THR_W-1:0] LAST = THR_W'(THRESHOLD - 1);

  logic [THR_W-1:0] thrCnt;
  logic             atLast;

  assign atLast = (thrCnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      thrCnt <= '0;
    end else if (en) begin
      if (atLast) thrCnt <= '0;
      else        thrCnt <= thrCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.tick      = en;
    strobes.wrap      = en && atLast;
    strobes.beatStart = en && atLast && !divClk;
  end

endmodule

// File: rtl/rate_div_dp.sv
module rate_div_dp
  import rate_div_pkg::*;
#(
  parameter int POW_WIDTH = 27,
  parameter int ON_TIME   = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  divStrobe_t strobes,
  output logic       powClk,
  output logic       divClk,
  output logic       heartbeat
);

  localparam int ON_W = cntWidth(ON_TIME);
  localparam logic [ON_W-1:0] ON_LOAD = ON_W'(ON_TIME - 1);

  logic [POW_WIDTH-1:0] powCnt;
  logic [ON_W-1:0]      onLeft;

  // Free-running overflow counter; the tap is its top bit.
  always_ff @(posedge clk) begin
    if (rst)               powCnt <= '0;
    else if (strobes.tick) powCnt <= powCnt + 1'b1;
  end

  assign powClk = powCnt[POW_WIDTH-1];

  // Square wave toggled by each threshold wrap.
  always_ff @(posedge clk) begin
    if (rst)               divClk <= 1'b0;
    else if (strobes.wrap) divClk <= ~divClk;
  end

  // Heartbeat: starts with the rising divided clock, lasts ON_TIME ticks.
  always_ff @(posedge clk) begin
    if (rst) begin
      heartbeat <= 1'b0;
      onLeft    <= '0;
    end else if (strobes.beatStart) begin
      heartbeat <= 1'b1;
      onLeft    <= ON_LOAD;
    end else if (strobes.tick && heartbeat) begin
      if (onLeft == '0) heartbeat <= 1'b0;
      else              onLeft    <= onLeft - 1'b1;
    end
  end

endmodule

// File: rtl/rate_divider.sv
module rate_divider
  import rate_div_pkg::*;
#(
  parameter int POW_WIDTH = 27,
  parameter int THRESHOLD = 50_000_000,
  parameter int ON_TIME   = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic powClk,
  output logic divClk,
  output logic heartbeat
);

  generate
    if (POW_WIDTH < 1) begin : g_badPow
      $error("POW_WIDTH must be at least 1");
    end
    if (THRESHOLD < 1) begin : g_badThr
      $error("THRESHOLD must be at least 1");
    end
    if (ON_TIME < 1 || ON_TIME >= 2 * THRESHOLD) begin : g_badOn
      $error("ON_TIME must be in 1 .. 2*THRESHOLD-1");
    end
  endgenerate

  divStrobe_t strobes;

  rate_div_ctrl #(
    .THRESHOLD(THRESHOLD)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .divClk (divClk),
    .strobes(strobes)
  );

  rate_div_dp #(
    .POW_WIDTH(POW_WIDTH),
    .ON_TIME  (ON_TIME)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .powClk   (powClk),
    .divClk   (divClk),
    .heartbeat(heartbeat)
  );

endmodule

// File: rtl/rate_divider_checker.sv
module rate_divider_checker #(
  parameter int ON_TIME = 1
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic powClk,
  input logic divClk,
  input logic heartbeat
);

  localparam int RUN_W = $clog2(ON_TIME + 2);

  logic [RUN_W-1:0] hiRun;

  // Enabled edges seen while the heartbeat has been high.
  always_ff @(posedge clk) begin
    if (rst || !heartbeat) hiRun <= '0;
    else if (en)           hiRun <= hiRun + 1'b1;
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!powClk && !divClk && !heartbeat));

  assert_beat_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(heartbeat) |-> $rose(divClk));

  assert_rise_gives_beat_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(divClk) |-> $rose(heartbeat));

  assert_beat_width_R5: assert property (@(posedge clk) disable iff (rst)
    heartbeat |-> (hiRun < RUN_W'(ON_TIME)));

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(powClk) && $stable(divClk) && $stable(heartbeat)));

endmodule

bind rate_divider rate_divider_checker #(.ON_TIME(ON_TIME)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .powClk   (powClk),
  .divClk   (divClk),
  .heartbeat(heartbeat)
);

// File: tb/rate_divider_test.sv
module rate_divider_test;

  localparam int W_A   = 4;
  localparam int THR_A = 3;
  localparam int ON_A  = 2;
  localparam int THR_B = 1;
  localparam int ON_B  = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic powA, divA, hbA;
  logic powB, divB, hbB;

  int checks = 0;
  int errors = 0;
  int nEdges = 0;   // enabled edges since last reset
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rate_divider #(.POW_WIDTH(W_A), .THRESHOLD(THR_A), .ON_TIME(ON_A)) uut (
    .clk(clk), .rst(rst), .en(en),
    .powClk(powA), .divClk(divA), .heartbeat(hbA)
  );

  rate_divider #(.POW_WIDTH(2), .THRESHOLD(THR_B), .ON_TIME(ON_B)) uutEdge (
    .clk(clk), .rst(rst), .en(en),
    .powClk(powB), .divClk(divB), .heartbeat(hbB)
  );

  function automatic logic expPow(input int n, input int w);
    return logic'((n >> (w - 1)) & 1);
  endfunction

  function automatic logic expDiv(input int n, input int t);
    return logic'((n / t) % 2);
  endfunction

  function automatic logic expBeat(input int n, input int t, input int on);
    int m;
    m = n % (2 * t);
    return (m >= t) && (m < t + on);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: n=%0d actual=%b expected=%b", tag, nEdges, act, exp);
    end
  endtask

  task automatic checkAll(input string ctx);
    check({ctx, " R2 powClk"},    powA, expPow(nEdges, W_A));
    check({ctx, " R3 divClk"},    divA, expDiv(nEdges, THR_A));
    check({ctx, " R4 R5 beat"},   hbA,  expBeat(nEdges, THR_A, ON_A));
    check({ctx, " R7 edge div"},  divB, expDiv(nEdges, THR_B));
    check({ctx, " R7 edge beat"}, hbB,  expBeat(nEdges, THR_B, ON_B));
    check({ctx, " R7 edge pow"},  powB, expPow(nEdges, 2));
  endtask

  // One clock: drive at the falling edge, sample 1 ns after the rising edge.
  task automatic step(input logic enVal, input logic rstVal);
    @(negedge clk);
    en  = enVal;
    rst = rstVal;
    @(posedge clk);
    if (rstVal)     nEdges = 0;
    else if (enVal) nEdges++;
    #1;
  endtask

  task automatic testReset();
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    check("R1 powClk", powA, 1'b0);
    check("R1 divClk", divA, 1'b0);
    check("R1 beat",   hbA,  1'b0);
    check("R1 edge div",  divB, 1'b0);
    check("R1 edge beat", hbB,  1'b0);
  endtask

  task automatic testFreeRun();
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b0);
      checkAll("run");
    end
  endtask

  task automatic testHold();
    for (int i = 0; i < 30; i++) begin
      logic e;
      e = (i % 3) != 1;
      if (i >= 20 && i < 25) e = 1'b0;
      step(e, 1'b0);
      checkAll(e ? "hold-run" : "R6 hold");
    end
  endtask

  task automatic testMidReset();
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check("R1 mid powClk", powA, 1'b0);
    check("R1 mid divClk", divA, 1'b0);
    check("R1 mid beat",   hbA,  1'b0);
    for (int i = 0; i < 14; i++) begin
      step(1'b1, 1'b0);
      checkAll("after-reset");
    end
  endtask

  initial begin
    testReset();
    testFreeRun();
    testHold();
    testMidReset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule